// File: doc/BRIEF.md
# Dual-Table Backlight Level Controller

This block holds the panel backlight level as a 4-bit index (sixteen steps, 0 to 15). It turns that index into an 8-bit duty value and drives a pulse-width-modulated backlight output. Two single-cycle key pulses step the level up or down, and the level stops at both ends. A restore strobe puts the level back at the brightest step. At start-up a load port accepts a previously saved index.

The duty value comes from one of two brightness curves, selected by a power-source flag: one curve for mains power and one for battery. The curve selection is combinational. The compare value that the PWM counter uses is taken only at the wrap of a PWM period, so a change of source or level never cuts a pulse short. Whenever a key press or a restore sets the level, the block presents the new index with a one-cycle write strobe, so that external storage can keep it.

Top module: `bl_level_ctrl`

## Requirements
- R1: After reset the index is 15, the write strobe is low and the PWM output is low until the first period wrap.
- R2: A brightness-up pulse alone, below index 15, raises the index by one. In the next cycle the new index appears on `persist_idx` with `persist_we` high for exactly one cycle.
- R3: A brightness-down pulse alone, above index 0, lowers the index by one, with the same one-cycle write strobe.
- R4: An up pulse at index 15 or a down pulse at index 0 leaves the index unchanged and raises no write strobe.
- R5: Up and down pulses in the same cycle leave the index unchanged and raise no write strobe.
- R6: A restore strobe sets the index to 15 and always raises the write strobe, even when the index is already 15. It takes priority over load and key inputs.
- R7: A load strobe copies `load_idx` into the index without raising the write strobe. It takes priority over key inputs.
- R8: With `on_ac` = 1, the duty for index i is 0x15 + 0x0F·i for i = 0..6 and 0x7F + 0x10·(i−7) for i = 7..15.
- R9: With `on_ac` = 0, the duty for index i is 0x0F·(i+1), which gives 0x0F up to 0xF0.
- R10: The PWM counter is 8 bits wide and advances only on cycles with `tick_en` high, so one period is 256 ticks. The output is high while the counter is below the compare value, which gives exactly `duty` high ticks per period.
- R11: A change of power source or level reaches the compare value only at the wrap from 255 to 0. The period already under way keeps its old duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | PWM counter clock enable |
| key_up | input | 1 | Brightness-up pulse |
| key_dn | input | 1 | Brightness-down pulse |
| on_ac | input | 1 | 1 = mains curve, 0 = battery curve |
| restore_def | input | 1 | Force index to 15 and write it |
| load_vld | input | 1 | Load saved index |
| load_idx | input | 4 | Saved index to load |
| persist_we | output | 1 | One-cycle write strobe for storage |
| persist_idx | output | 4 | Current index |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The duty curves are checked by measuring the high time of whole PWM periods for all sixteen levels on each source. This tells an error in a single table entry apart from a wrong choice of curve. A source switch in the middle of a period, at a counter position between the old and the new compare value, shows whether the compare value is reloaded early. A stall of `tick_en` in the middle of a period shows whether the counter advances without an enable. Key sequences at both ends and with both keys pressed together, plus restore and load pulses mixed with key pulses, check saturation, input priority and when the write strobe must or must not appear.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int IDX_W  = 4;
  localparam int DUTY_W = 8;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_UP,
    ACT_DOWN,
    ACT_RESTORE,
    ACT_LOAD
  } lvl_act_e;

  // Mains curve: linear 0x0F steps up to index 6, then 0x10 steps ending at full scale.
  function automatic logic [DUTY_W-1:0] ac_duty(input logic [IDX_W-1:0] i);
    logic [DUTY_W-1:0] r;
    if (i < IDX_W'(7)) r = DUTY_W'(8'h15 + 8'(i) * 8'h0F);
    else               r = DUTY_W'(8'h7F + {4'(i - IDX_W'(7)), 4'h0});
    return r;
  endfunction

  // Battery curve: a plain multiple of 0x0F.
  function automatic logic [DUTY_W-1:0] dc_duty(input logic [IDX_W-1:0] i);
    return DUTY_W'(8'(i) * 8'h0F + 8'h0F);
  endfunction
endpackage

// File: rtl/bl_level_reg.sv
module bl_level_reg #(
  parameter int IDX_W = bl_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_up,
  input  logic             key_dn,
  input  logic             restore_def,
  input  logic             load_vld,
  input  logic [IDX_W-1:0] load_idx,
  output logic [IDX_W-1:0] idx_q,
  output logic             wr_q,
  output logic             ev_up,
  output logic             ev_dn
);
  import bl_pkg::*;
  localparam logic [IDX_W-1:0] TOP_IDX = '1;
  localparam logic [IDX_W-1:0] BOT_IDX = '0;

  lvl_act_e act;

  always_comb begin
    if (restore_def)                                 act = ACT_RESTORE;
    else if (load_vld)                               act = ACT_LOAD;
    else if (key_up && !key_dn && idx_q != TOP_IDX)  act = ACT_UP;
    else if (key_dn && !key_up && idx_q != BOT_IDX)  act = ACT_DOWN;
    else                                             act = ACT_NONE;
  end

  assign ev_up = (act == ACT_UP);
  assign ev_dn = (act == ACT_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= TOP_IDX;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      case (act)
        ACT_RESTORE: begin idx_q <= TOP_IDX;          wr_q <= 1'b1; end
        ACT_LOAD:    begin idx_q <= load_idx;                       end
        ACT_UP:      begin idx_q <= idx_q + IDX_W'(1); wr_q <= 1'b1; end
        ACT_DOWN:    begin idx_q <= idx_q - IDX_W'(1); wr_q <= 1'b1; end
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/bl_duty_lut.sv
module bl_duty_lut #(
  parameter int IDX_W  = bl_pkg::IDX_W,
  parameter int DUTY_W = bl_pkg::DUTY_W
) (
  input  logic              on_ac,
  input  logic [IDX_W-1:0]  idx,
  output logic [DUTY_W-1:0] duty
);
  localparam int LEVELS = 1 << IDX_W;

  logic [DUTY_W-1:0] ac_tab [LEVELS];
  logic [DUTY_W-1:0] dc_tab [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_tab
    assign ac_tab[g] = bl_pkg::ac_duty(IDX_W'(g));
    assign dc_tab[g] = bl_pkg::dc_duty(IDX_W'(g));
  end

  assign duty = on_ac ? ac_tab[idx] : dc_tab[idx];
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter int DUTY_W = bl_pkg::DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [DUTY_W-1:0] target,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] cnt_q,
  output logic [DUTY_W-1:0] cmp_q,
  output logic              wrap
);
  localparam logic [DUTY_W-1:0] CNT_LAST = '1;

  assign wrap = tick_en && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (tick_en) cnt_q <= cnt_q + DUTY_W'(1);
      if (wrap)    cmp_q <= target;
    end
  end

  assign pwm_out = (cnt_q < cmp_q);
endmodule

// File: rtl/bl_level_ctrl.sv
module bl_level_ctrl #(
  parameter int IDX_W  = bl_pkg::IDX_W,
  parameter int DUTY_W = bl_pkg::DUTY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             key_up,
  input  logic             key_dn,
  input  logic             on_ac,
  input  logic             restore_def,
  input  logic             load_vld,
  input  logic [IDX_W-1:0] load_idx,
  output logic             persist_we,
  output logic [IDX_W-1:0] persist_idx,
  output logic             pwm_out
);
  logic              ev_up, ev_dn, ev_wrap;
  logic [DUTY_W-1:0] target_duty, cmp_val, cnt_val;

  bl_level_reg #(.IDX_W(IDX_W)) u_level (
    .clk(clk), .rst_n(rst_n), .key_up(key_up), .key_dn(key_dn),
    .restore_def(restore_def), .load_vld(load_vld), .load_idx(load_idx),
    .idx_q(persist_idx), .wr_q(persist_we), .ev_up(ev_up), .ev_dn(ev_dn)
  );

  bl_duty_lut #(.IDX_W(IDX_W), .DUTY_W(DUTY_W)) u_lut (
    .on_ac(on_ac), .idx(persist_idx), .duty(target_duty)
  );

  bl_pwm_gen #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .target(target_duty),
    .pwm_out(pwm_out), .cnt_q(cnt_val), .cmp_q(cmp_val), .wrap(ev_wrap)
  );
endmodule

// File: rtl/bl_level_ctrl_chk.sv
module bl_level_ctrl_chk #(
  parameter int IDX_W  = 4,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              key_up,
  input logic              key_dn,
  input logic              restore_def,
  input logic              load_vld,
  input logic              persist_we,
  input logic [IDX_W-1:0]  persist_idx,
  input logic              ev_up,
  input logic              ev_dn,
  input logic              ev_wrap,
  input logic [DUTY_W-1:0] cmp_val,
  input logic [DUTY_W-1:0] cnt_val
);
  localparam logic [IDX_W-1:0] TOP_IDX = '1;
  localparam logic [IDX_W-1:0] BOT_IDX = '0;

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_up |=> (persist_we && persist_idx == IDX_W'($past(persist_idx) + IDX_W'(1))));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dn |=> (persist_we && persist_idx == IDX_W'($past(persist_idx) - IDX_W'(1))));

  assert_top_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_up && !key_dn && !restore_def && !load_vld && persist_idx == TOP_IDX)
      |=> (persist_idx == TOP_IDX && !persist_we));

  assert_bottom_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_dn && !key_up && !restore_def && !load_vld && persist_idx == BOT_IDX)
      |=> (persist_idx == BOT_IDX && !persist_we));

  assert_both_keys_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_up && key_dn && !restore_def && !load_vld) |=> ($stable(persist_idx) && !persist_we));

  assert_restore_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_def |=> (persist_idx == TOP_IDX && persist_we));

  assert_load_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_vld && !restore_def) |=> !persist_we);

  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_val));

  assert_cmp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wrap |=> $stable(cmp_val));
endmodule

bind bl_level_ctrl bl_level_ctrl_chk #(.IDX_W(IDX_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .key_up(key_up), .key_dn(key_dn),
  .restore_def(restore_def), .load_vld(load_vld), .persist_we(persist_we),
  .persist_idx(persist_idx), .ev_up(ev_up), .ev_dn(ev_dn), .ev_wrap(ev_wrap),
  .cmp_val(cmp_val), .cnt_val(cnt_val)
);

// File: tb/bl_level_ctrl_bench.sv
module bl_level_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       key_up = 1'b0, key_dn = 1'b0, on_ac = 1'b1;
  logic       restore_def = 1'b0, load_vld = 1'b0;
  logic [3:0] load_idx = 4'h0;
  logic       persist_we, pwm_out;
  logic [3:0] persist_idx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bl_level_ctrl u_bl_level_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .key_up(key_up), .key_dn(key_dn),
    .on_ac(on_ac), .restore_def(restore_def), .load_vld(load_vld), .load_idx(load_idx),
    .persist_we(persist_we), .persist_idx(persist_idx), .pwm_out(pwm_out)
  );

  function automatic int exp_ac(input int i);
    return (i <= 6) ? (21 + 15 * i) : (16 * i + 15);
  endfunction
  function automatic int exp_dc(input int i);
    return 15 * i + 15;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_lvl(input string req, input int idx, input int we);
    check(persist_idx == 4'(idx), req, persist_idx, idx);
    check(persist_we == we[0], req, persist_we, we);
  endtask

  // drive one cycle of inputs at negedge, sample at the next negedge
  task automatic pulse(input bit up, input bit dn, input bit rs, input bit ld, input int li);
    key_up = up; key_dn = dn; restore_def = rs; load_vld = ld; load_idx = 4'(li);
    @(negedge clk);
    key_up = 0; key_dn = 0; restore_def = 0; load_vld = 0;
  endtask

  task automatic wait_rise();
    bit prev;
    prev = pwm_out;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (pwm_out && !prev) return;
      prev = pwm_out;
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_lvl("R1 reset index/strobe", 15, 0);
    check(pwm_out == 0, "R1 reset pwm", pwm_out, 0);
    rst_n = 1;
    @(negedge clk);
    check(pwm_out == 0, "R1 pwm low before first wrap", pwm_out, 0);
  endtask

  task automatic t_keys();
    pulse(1, 0, 0, 0, 0); check_lvl("R4 up at top", 15, 0);
    pulse(0, 0, 0, 1, 0); check_lvl("R7 load zero silent", 0, 0);
    pulse(0, 1, 0, 0, 0); check_lvl("R4 down at bottom", 0, 0);
    pulse(1, 0, 0, 0, 0); check_lvl("R2 up step", 1, 1);
    @(negedge clk);       check_lvl("R2 strobe one cycle", 1, 0);
    pulse(1, 0, 0, 0, 0); check_lvl("R2 up again", 2, 1);
    pulse(0, 1, 0, 0, 0); check_lvl("R3 down step", 1, 1);
    @(negedge clk);       check_lvl("R3 strobe one cycle", 1, 0);
    pulse(1, 1, 0, 0, 0); check_lvl("R5 both keys", 1, 0);
  endtask

  task automatic t_priority();
    pulse(1, 0, 0, 1, 5); check_lvl("R7 load beats key", 5, 0);
    pulse(1, 0, 1, 1, 3); check_lvl("R6 restore beats load/key", 15, 1);
    pulse(0, 0, 1, 0, 0); check_lvl("R6 restore at top still writes", 15, 1);
    @(negedge clk);       check_lvl("R6 strobe one cycle", 15, 0);
  endtask

  task automatic t_tables(input bit ac);
    int hi, exp;
    on_ac = ac;
    for (int i = 0; i < 16; i++) begin
      pulse(0, 0, 0, 1, i);
      wait_rise();
      count_high(256, hi);
      exp = ac ? exp_ac(i) : exp_dc(i);
      check(hi == exp, ac ? "R8 mains duty" : "R9 battery duty", hi, exp);
    end
  endtask

  task automatic t_switch();
    int hi;
    on_ac = 1;
    pulse(0, 0, 0, 1, 3);
    wait_rise(); count_high(256, hi);
    check(hi == 66, "R11 settle mains idx3", hi, 66);
    wait_rise();
    repeat (62) @(negedge clk);
    on_ac = 0;
    count_high(194, hi);
    check(hi == 4, "R11 old duty kept to period end", hi, 4);
    count_high(256, hi);
    check(hi == 60, "R11 new duty after wrap", hi, 60);
  endtask

  task automatic t_tick_gate();
    int hi;
    bit ok;
    on_ac = 1;
    pulse(0, 0, 0, 1, 15);
    wait_rise(); count_high(256, hi);
    check(hi == 255, "R10 full-scale period", hi, 255);
    wait_rise();
    repeat (10) @(negedge clk);
    tick_en = 0;
    ok = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!pwm_out) ok = 0;
    end
    check(ok, "R10 output frozen while gated", ok, 1);
    tick_en = 1;
    count_high(246, hi);
    check(hi == 245, "R10 counter resumes from stall point", hi, 245);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_keys();
    t_priority();
    t_tables(1);
    t_tables(0);
    t_switch();
    t_tick_gate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule